// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a byte-wide synchronous serial port. A transmit path and a receive path share one serial clock. The clock can come from an on-block divider, in which case the block drives it out and marks the pin as driven. It can also come from an outside master through a clock input, which the block synchronizes into its own clock domain. Each character is eight bits long and carries no parity. Bits go out and come in least significant first. Transmit data changes on the falling serial edge, and both directions sample on the rising edge.

The host writes a transmit holding register and reads a receive holding register with single-cycle strobes. It controls the two paths with level enables. It watches three flags: transmit-empty, receive-full and overrun. When the internal clock is selected and only receive is enabled, the serial clock runs on its own from character to character. It stops when an overrun is raised or when receive is turned off. When transmit is enabled, the clock runs only while there is data to send. Consecutive bytes follow with no idle clock between them when the host refills the holding register in time.

Top module: `ser_sync_xcvr`

## Requirements
- R1: A transmitted character is 8 bits, least significant bit first. `sdata_out` changes only at falling serial-clock edges and is stable at every rising edge.
- R2: After the last bit of a character, `sdata_out` stays at that bit's value (the MSB) until the next character starts.
- R3: With `cfg_ext_clk`=0, `sclk_oe`=1 and the serial clock period is 2×(`cfg_div`+1) system clocks. Exactly 8 rising edges are issued per character.
- R4: With `cfg_ext_clk`=1, `sclk_oe`=0 and `sclk_out` is held at 1. Bits are shifted on the edges of `sclk_in` after a two-stage synchronizer, so they act at most 3 system clocks after the edge.
- R5: When the 8th bit of a character is sampled, the assembled byte (first bit received = bit 0) appears on `rx_data` and `rx_full` goes to 1. A read strobe `rx_rd` clears `rx_full`.
- R6: If a character completes while `rx_full`=1 and no read happens in that cycle, `ovr_err` goes to 1. `rx_data` keeps the older byte, and no byte is taken in until `ovr_clr` is pulsed.
- R7: With the internal clock, receive enabled and transmit disabled, the serial clock keeps running even while `rx_full`=1. It stops (held at 1) in the cycle an overrun is raised.
- R8: While `tx_en`=0, `tx_empty` is 1 and any partly sent character is abandoned: the internal clock stops and `sdata_out` holds. A `tx_wr` issued while `tx_en`=0 is ignored.
- R9: While `rx_en`=0, `rx_full`, `ovr_err` and `rx_data` keep their values, except for a host read or clear.
- R10: The holding register moves to the shift register at the first falling edge of a character, and `tx_empty` returns to 1 in that cycle. If a new byte was written before the last rising edge, the next character follows with no idle clock period.
- R11: A read strobe in the same cycle as a character completion stores the new byte and leaves `rx_full`=1 without raising `ovr_err`.
- R12: After reset, `sclk_out`=1, `sclk_oe`=1, `sdata_out`=1, `tx_empty`=1, `rx_full`=0 and `ovr_err`=0. With the internal clock, `sclk_out` is 1 whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_ext_clk | input | 1 | 0: internal divider clock, 1: external clock input |
| cfg_div | input | DIV_W | Divider value N; serial period 2×(N+1) system clocks |
| tx_en | input | 1 | Transmit path enable |
| rx_en | input | 1 | Receive path enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | CHAR_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe, clears receive-full |
| ovr_clr | input | 1 | Clears the overrun flag |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Serial clock driven by the block |
| sclk_oe | output | 1 | High when `sclk_out` should drive the clock pin |
| sdata_in | input | 1 | Serial receive data |
| sdata_out | output | 1 | Serial transmit data |
| tx_empty | output | 1 | Transmit holding register can accept a byte |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| rx_data | output | CHAR_W | Receive holding register |
| ovr_err | output | 1 | Overrun flag |

## Verification
A host read and a character completion can fall in the same system cycle. The block must then take the new byte without raising overrun. The bench runs receive-only with the internal clock, where the completion instants are exactly 16×(N+1) cycles apart. It times a read strobe to land on the second completion edge. It then judges that `rx_full` is still 1, `ovr_err` is 0 and `rx_data` holds the second byte. A later completion with no read then confirms that overrun is raised and the clock stops.

// File: rtl/ser_pkg.sv
package ser_pkg;

   typedef enum logic {
      CLK_INTERNAL = 1'b0,
      CLK_EXTERNAL = 1'b1
   } clk_src_e;

   typedef struct packed {
      logic rise;
      logic fall;
   } sclk_evt_t;

endpackage

// File: rtl/ser_clk_unit.sv
module ser_clk_unit
   import ser_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  clk_src_e          src,
   input  logic [DIV_W-1:0]  div,
   input  logic              halt,
   input  logic              run_req,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   output sclk_evt_t         evt,
   output logic              first_bit,
   output logic              last_bit
);

   localparam int IDX_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHAR_W - 1);

   // internal divider engine
   logic             int_active;
   logic             int_sclk;
   logic [DIV_W-1:0] half_cnt;
   logic             tick;
   logic             int_rise;
   logic             int_fall;

   assign tick     = int_active && (half_cnt == div);
   assign int_rise = tick && !int_sclk;
   assign int_fall = tick &&  int_sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         int_active <= 1'b0;
         int_sclk   <= 1'b1;
         half_cnt   <= '0;
      end else if (src == CLK_EXTERNAL || halt) begin
         int_active <= 1'b0;
         int_sclk   <= 1'b1;
         half_cnt   <= '0;
      end else if (!int_active) begin
         half_cnt <= '0;
         if (run_req) int_active <= 1'b1;
      end else if (tick) begin
         half_cnt <= '0;
         int_sclk <= ~int_sclk;
         if (int_rise && last_bit && !run_req) int_active <= 1'b0;
      end else begin
         half_cnt <= half_cnt + 1'b1;
      end
   end

   // external clock synchronizer and edge detector
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev;
   logic                   ext_lvl;

   assign ext_lvl = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= '1;
         ext_prev <= 1'b1;
      end else begin
         sync_q   <= {sync_q[SYNC_STAGES-2:0], sclk_in};
         ext_prev <= ext_lvl;
      end
   end

   always_comb begin
      if (src == CLK_EXTERNAL) begin
         evt.rise = !halt &&  ext_lvl && !ext_prev;
         evt.fall = !halt && !ext_lvl &&  ext_prev;
      end else begin
         evt.rise = !halt && int_rise;
         evt.fall = !halt && int_fall;
      end
   end

   // bit position within the character, advanced on sampling edges
   logic [IDX_W-1:0] bit_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_idx <= '0;
      end else if (halt || (src == CLK_INTERNAL && !int_active)) begin
         bit_idx <= '0;
      end else if (evt.rise) begin
         bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
      end
   end

   assign first_bit = (bit_idx == '0);
   assign last_bit  = (bit_idx == LAST_IDX);
   assign sclk_out  = (src == CLK_EXTERNAL) ? 1'b1 : int_sclk;
   assign sclk_oe   = (src == CLK_INTERNAL);

endmodule

// File: rtl/ser_tx_path.sv
module ser_tx_path #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr,
   input  logic [CHAR_W-1:0] wdata,
   input  logic              rise_p,
   input  logic              fall_p,
   input  logic              first_bit,
   input  logic              last_bit,
   output logic              sdata_out,
   output logic              tx_empty
);

   logic [CHAR_W-1:0] hold_q;
   logic [CHAR_W-1:0] shift_q;
   logic              busy_q;
   logic              load;

   assign load = tx_en && fall_p && first_bit && !tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         shift_q   <= '0;
         busy_q    <= 1'b0;
         tx_empty  <= 1'b1;
         sdata_out <= 1'b1;
      end else if (!tx_en) begin
         shift_q  <= '0;
         busy_q   <= 1'b0;
         tx_empty <= 1'b1;
      end else begin
         if (load) begin
            sdata_out <= hold_q[0];
            shift_q   <= hold_q >> 1;
            busy_q    <= 1'b1;
         end else if (busy_q && fall_p) begin
            sdata_out <= shift_q[0];
            shift_q   <= shift_q >> 1;
         end
         if (busy_q && rise_p && last_bit) busy_q <= 1'b0;
         if (wr) begin
            hold_q   <= wdata;
            tx_empty <= 1'b0;
         end else if (load) begin
            tx_empty <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ser_rx_path.sv
module ser_rx_path #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rd,
   input  logic              clr_ovr,
   input  logic              rise_p,
   input  logic              last_bit,
   input  logic              sdata_in,
   output logic [CHAR_W-1:0] rx_data,
   output logic              rx_full,
   output logic              ovr_err,
   output logic              ovr_set
);

   logic [CHAR_W-1:0] shift_q;
   logic [CHAR_W-1:0] shift_nxt;
   logic              take;
   logic              done;

   assign take      = rx_en && !ovr_err && rise_p;
   assign done      = take && last_bit;
   assign shift_nxt = {sdata_in, shift_q[CHAR_W-1:1]};
   assign ovr_set   = done && rx_full && !rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         rx_data <= '0;
         rx_full <= 1'b0;
         ovr_err <= 1'b0;
      end else begin
         if (take) shift_q <= shift_nxt;
         if (done && !ovr_set) begin
            rx_data <= shift_nxt;
            rx_full <= 1'b1;
         end else if (rd) begin
            rx_full <= 1'b0;
         end
         if (ovr_set)      ovr_err <= 1'b1;
         else if (clr_ovr) ovr_err <= 1'b0;
      end
   end

endmodule

// File: rtl/ser_sync_xcvr.sv
module ser_sync_xcvr
   import ser_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int CHAR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ext_clk,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              tx_wr,
   input  logic [CHAR_W-1:0] tx_wdata,
   input  logic              rx_rd,
   input  logic              ovr_clr,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   input  logic              sdata_in,
   output logic              sdata_out,
   output logic              tx_empty,
   output logic              rx_full,
   output logic [CHAR_W-1:0] rx_data,
   output logic              ovr_err
);

   generate
      if (CHAR_W < 2) begin : g_bad_char
         $error("CHAR_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   clk_src_e  src;
   sclk_evt_t evt;
   logic      halt;
   logic      run_req;
   logic      first_bit;
   logic      last_bit;
   logic      ovr_set;

   assign src  = clk_src_e'(cfg_ext_clk);
   assign halt = !tx_en && !rx_en;

   // transmit mode clocks only on data; receive-only free-runs until overrun
   assign run_req = tx_en ? !tx_empty : (rx_en && !ovr_err && !ovr_set);

   ser_clk_unit #(
      .DIV_W       (DIV_W),
      .CHAR_W      (CHAR_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .src       (src),
      .div       (cfg_div),
      .halt      (halt),
      .run_req   (run_req),
      .sclk_in   (sclk_in),
      .sclk_out  (sclk_out),
      .sclk_oe   (sclk_oe),
      .evt       (evt),
      .first_bit (first_bit),
      .last_bit  (last_bit)
   );

   ser_tx_path #(.CHAR_W(CHAR_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .wr        (tx_wr),
      .wdata     (tx_wdata),
      .rise_p    (evt.rise),
      .fall_p    (evt.fall),
      .first_bit (first_bit),
      .last_bit  (last_bit),
      .sdata_out (sdata_out),
      .tx_empty  (tx_empty)
   );

   ser_rx_path #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .rd       (rx_rd),
      .clr_ovr  (ovr_clr),
      .rise_p   (evt.rise),
      .last_bit (last_bit),
      .sdata_in (sdata_in),
      .rx_data  (rx_data),
      .rx_full  (rx_full),
      .ovr_err  (ovr_err),
      .ovr_set  (ovr_set)
   );

endmodule

module ser_sync_xcvr_chk #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_ext_clk,
   input logic              tx_en,
   input logic              rx_en,
   input logic              rx_rd,
   input logic              ovr_clr,
   input logic              sclk_out,
   input logic              sdata_out,
   input logic              tx_empty,
   input logic              rx_full,
   input logic [CHAR_W-1:0] rx_data,
   input logic              ovr_err
);

   // R1
   data_stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ext_clk && $rose(sclk_out)) |-> $stable(sdata_out));

   // R12
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_ext_clk && !tx_en && !rx_en) |=> sclk_out);

   // R8
   tx_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> tx_empty);

   // R9
   rx_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !rx_rd && !ovr_clr) |=> ($stable(rx_full) && $stable(rx_data) && $stable(ovr_err)));

   // R6
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && !ovr_clr) |=> ovr_err);

   // R6
   ovr_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> ($stable(rx_data) && rx_full));

endmodule

bind ser_sync_xcvr ser_sync_xcvr_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_ext_clk (cfg_ext_clk),
   .tx_en       (tx_en),
   .rx_en       (rx_en),
   .rx_rd       (rx_rd),
   .ovr_clr     (ovr_clr),
   .sclk_out    (sclk_out),
   .sdata_out   (sdata_out),
   .tx_empty    (tx_empty),
   .rx_full     (rx_full),
   .rx_data     (rx_data),
   .ovr_err     (ovr_err)
);

// File: tb/sim_ser_sync_xcvr.sv
`timescale 1ns/1ps
module sim_ser_sync_xcvr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_ext_clk = 1'b0;
   logic [7:0] cfg_div = 8'd3;
   logic       tx_en = 1'b0, rx_en = 1'b0, tx_wr = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic       rd_auto = 1'b0, rd_man = 1'b0, ovr_clr = 1'b0;
   logic       sclk_in = 1'b1;
   logic       model_bit = 1'b1, loop = 1'b0;
   wire        rx_rd = rd_auto | rd_man;
   wire        sclk_out, sclk_oe, sdata_out, tx_empty, rx_full, ovr_err;
   wire [7:0]  rx_data;
   wire        sdata_in = loop ? sdata_out : model_bit;
   wire        mon_clk = cfg_ext_clk ? sclk_in : sclk_out;

   int n_cmp = 0, n_bad = 0;
   int cyc = 0;
   logic [7:0] txq[$], rxq[$];

   ser_sync_xcvr u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div),
      .tx_en(tx_en), .rx_en(rx_en), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .ovr_clr(ovr_clr), .sclk_in(sclk_in), .sclk_out(sclk_out),
      .sclk_oe(sclk_oe), .sdata_in(sdata_in), .sdata_out(sdata_out),
      .tx_empty(tx_empty), .rx_full(rx_full), .rx_data(rx_data), .ovr_err(ovr_err)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int k);
      return 8'h1B + 8'(k) * 8'h4D;
   endfunction

   // driver: push expectation, then write the holding register
   task automatic send(input logic [7:0] b);
      txq.push_back(b);
      if (loop) rxq.push_back(b);
      @(negedge clk); tx_wr = 1'b1; tx_wdata = b;
      @(negedge clk); tx_wr = 1'b0;
   endtask

   // transmit monitor: one bit per rising serial edge
   logic       mon_on = 1'b0, gap_chk = 1'b0, first_rise = 1'b1;
   int         rise_cnt = 0, last_rise = 0, mon_nb = 0;
   logic [7:0] mon_sh = '0;
   always @(posedge mon_clk) begin
      if (mon_on) begin
         rise_cnt++;
         if (gap_chk && !first_rise)
            chk("R3 R10 serial period", cyc - last_rise, 2 * (int'(cfg_div) + 1));
         last_rise = cyc;
         first_rise = 1'b0;
         mon_sh = {sdata_out, mon_sh[7:1]};
         mon_nb++;
         if (mon_nb == 8) begin
            mon_nb = 0;
            if (txq.size() == 0) chk("R1 unexpected byte", mon_sh, 32'hFFFF);
            else chk("R1 serial byte LSB first", mon_sh, txq.pop_front());
         end
      end
   end

   // receive monitor: read and compare whenever a byte is waiting
   logic auto_rd = 1'b0;
   always @(negedge clk) begin
      if (rd_auto) rd_auto = 1'b0;
      else if (auto_rd && rx_full) begin
         if (rxq.size() == 0) chk("R5 unexpected rx byte", rx_data, 32'hFFFF);
         else chk("R5 received byte", rx_data, rxq.pop_front());
         rd_auto = 1'b1;
      end
   end

   // external bit source for receive-only runs
   logic model_on = 1'b0;
   int   mbit = 0;
   always @(negedge sclk_out) begin
      if (model_on) begin
         model_bit = pat(mbit / 8)[mbit % 8];
         mbit++;
      end
   end

   task automatic ext_clocks(input int n);
      for (int i = 0; i < n; i++) begin
         sclk_in = 1'b0; repeat (10) @(negedge clk);
         sclk_in = 1'b1; repeat (10) @(negedge clk);
      end
   endtask

   task automatic drain();
      while (txq.size() != 0 || rxq.size() != 0) @(negedge clk);
      repeat (30) @(negedge clk);
   endtask

   task automatic pulse_rd();
      @(negedge clk); rd_man = 1'b1; @(negedge clk); rd_man = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      int lows;
      logic held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk("R12 sclk_out", sclk_out, 1);
      chk("R12 sclk_oe", sclk_oe, 1);
      chk("R12 sdata_out", sdata_out, 1);
      chk("R12 tx_empty", tx_empty, 1);
      chk("R12 rx_full", rx_full, 0);
      chk("R12 ovr_err", ovr_err, 0);

      // single byte, internal clock, loopback
      loop = 1'b1; auto_rd = 1'b1; mon_on = 1'b1; gap_chk = 1'b1;
      first_rise = 1'b1; rise_cnt = 0;
      tx_en = 1'b1; rx_en = 1'b1;
      send(8'hA5);
      drain();
      chk("R3 rises per character", rise_cnt, 8);
      chk("R2 line holds MSB", sdata_out, 1);
      chk("R12 idle clock high", sclk_out, 1);

      // back-to-back burst
      first_rise = 1'b1; rise_cnt = 0;
      send(8'hC4);
      while (!tx_empty) @(negedge clk);
      chk("R10 load at first falling edge", sclk_out, 0);
      send(8'h3A);
      drain();
      chk("R10 rises over two characters", rise_cnt, 16);
      chk("R2 line holds MSB 0", sdata_out, 0);

      // smallest divider
      tx_en = 1'b0; rx_en = 1'b0;
      @(negedge clk);
      cfg_div = 8'd0;
      tx_en = 1'b1; rx_en = 1'b1;
      first_rise = 1'b1; rise_cnt = 0;
      send(8'h5A);
      drain();
      chk("R3 rises with divider 0", rise_cnt, 8);
      tx_en = 1'b0; rx_en = 1'b0; auto_rd = 1'b0; mon_on = 1'b0; loop = 1'b0;
      cfg_div = 8'd3;
      @(negedge clk);

      // receive-only: continuous clock, read collision, overrun
      mbit = 0; model_on = 1'b1;
      rx_en = 1'b1;
      while (!rx_full) @(negedge clk);
      chk("R5 first byte", rx_data, pat(0));
      repeat (16 * (int'(cfg_div) + 1) - 1) @(negedge clk);
      rd_man = 1'b1;
      @(negedge clk);
      rd_man = 1'b0;
      chk("R11 full after collision", rx_full, 1);
      chk("R11 no overrun on collision", ovr_err, 0);
      chk("R11 second byte stored", rx_data, pat(1));
      chk("R7 clock ran while full", rx_data, pat(1));
      while (!ovr_err) @(negedge clk);
      chk("R6 old byte kept", rx_data, pat(1));
      chk("R6 still full", rx_full, 1);
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!sclk_out) lows++;
      end
      chk("R7 clock stopped after overrun", lows, 0);
      pulse_rd();
      repeat (40) @(negedge clk);
      chk("R6 nothing taken while overrun", rx_full, 0);
      pulse_clr();
      while (!rx_full) @(negedge clk);
      chk("R6 resumes after clear", rx_data, pat(3));
      while (!ovr_err) @(negedge clk);
      rx_en = 1'b0;
      repeat (20) @(negedge clk);
      chk("R9 full kept", rx_full, 1);
      chk("R9 overrun kept", ovr_err, 1);
      chk("R9 data kept", rx_data, pat(3));
      pulse_clr();
      pulse_rd();
      model_on = 1'b0;

      // transmit disable mid-character
      tx_en = 1'b1;
      @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'h81;
      @(negedge clk); tx_wr = 1'b0;
      repeat (3) @(negedge sclk_out);
      @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk("R8 empty after disable", tx_empty, 1);
      held = sdata_out;
      lows = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (!sclk_out || sdata_out !== held) lows++;
      end
      chk("R8 line and clock frozen", lows, 0);
      @(negedge clk); tx_wr = 1'b1; tx_wdata = 8'h77;
      @(negedge clk); tx_wr = 1'b0;
      chk("R8 write ignored while disabled", tx_empty, 1);
      tx_en = 1'b1;
      lows = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!sclk_out) lows++;
      end
      chk("R8 no transfer from ignored write", lows, 0);
      chk("R8 still empty", tx_empty, 1);
      tx_en = 1'b0;
      @(negedge clk);

      // external clock, loopback
      cfg_ext_clk = 1'b1;
      @(negedge clk);
      chk("R4 clock not driven", sclk_oe, 0);
      chk("R4 clock output parked", sclk_out, 1);
      loop = 1'b1; auto_rd = 1'b1; mon_on = 1'b1; gap_chk = 1'b0; mon_nb = 0;
      tx_en = 1'b1; rx_en = 1'b1;
      send(8'h6E);
      ext_clocks(8);
      repeat (10) @(negedge clk);
      chk("R4 transmit done by external clock", txq.size(), 0);
      chk("R4 receive done by external clock", rxq.size(), 0);
      tx_en = 1'b0; rx_en = 1'b0;
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule